// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces data-memory addresses for a signal-processing core. It keeps a small file of address pointer registers, one step (index) register and one buffer-length register. When the core strobes a request, the block returns the present value of the chosen pointer as the operand address. In the same clock edge it rewrites that pointer according to a 3-bit mode code. The modes are: leave unchanged, step up by one, step down by one, step up by one inside a circular buffer, or add the step register with the carry running from the top bit down to the bottom bit. The last mode walks FFT data in bit-reversed order.

A circular buffer is located by clearing the low bits of the pointer. The number of bits cleared is the smallest k for which 2^k is at least the buffer length, so every buffer starts on a power-of-two boundary. The length itself need not be a power of two. Pointers, step and length are written through separate load ports. The address comes out one clock after the request, with a valid flag.

Top module: `dsp_agu`

## Requirements
- R1: After a synchronous active-low reset, all pointers, the step register and the length register are zero, and `addr_valid` is 0.
- R2: A request sampled at a clock edge makes `addr_valid` 1 for the next cycle, with `addr_out` equal to the selected pointer's value before that edge. A cycle without a request gives `addr_valid` 0.
- R3: Mode codes 0, 5, 6 and 7 leave the selected pointer unchanged.
- R4: Mode code 1 adds one to the selected pointer, modulo 2^16.
- R5: Mode code 2 subtracts one from the selected pointer, modulo 2^16.
- R6: Mode code 3 works as follows. Let k be the smallest value with 2^k at least the length, base the pointer with its low k bits cleared, and offset the pointer minus base. If offset+1 is less than the length, the pointer becomes pointer+1. Otherwise it becomes base. A length of 0 or 1 leaves the pointer unchanged.
- R7: Mode code 4 replaces the selected pointer with the pointer plus the step register, added with the carry travelling from bit 15 toward bit 0; a carry out of bit 0 is dropped. With the step set to N/2 and the pointer starting at 0, successive accesses yield the bit-reversed sequence of 0..N-1.
- R8: A pointer load is written at the next edge. If the same pointer is requested in that cycle, the load wins and no post-modify occurs, though the address output still shows the pre-load value. A request to a different pointer in that cycle is updated normally.
- R9: Step and length loads take effect at the next edge. A request in the same cycle uses the previous step and length.
- R10: A request changes no pointer other than the selected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_sel | input | 3 | Pointer selected for the access |
| req_mode | input | 3 | Post-modify mode code |
| ld_ar_en | input | 1 | Pointer load enable |
| ld_ar_sel | input | 3 | Pointer to load |
| ld_ar_data | input | 16 | Pointer load value |
| ld_idx_en | input | 1 | Step register load enable |
| ld_idx_data | input | 16 | Step register load value |
| ld_blk_en | input | 1 | Length register load enable |
| ld_blk_data | input | 16 | Length register load value |
| addr_out | output | 16 | Operand address (pre-modify value) |
| addr_valid | output | 1 | Address valid, one cycle after a request |

## Verification
Two things can land on the same pointer in one cycle: a load from the core, and the post-modify of an access. The bench provokes this on purpose in a directed step. It loads a pointer while requesting an increment on it, and checks that the address shows the old value and a later read returns the loaded value. The random phase then mixes loads into access traffic with a free-running reference model, so loads to the accessed pointer, loads to another pointer, and step or length loads under a bit-reversed or circular access all occur and are judged every clock.

// File: rtl/dsp_agu_pkg.sv
// Package: shared mode encoding for the address generation unit.
// Assumes: mode codes 5..7 are unused and behave as hold.
package dsp_agu_pkg;
    typedef enum logic [2:0] {
        AM_HOLD = 3'd0,
        AM_INC  = 3'd1,
        AM_DEC  = 3'd2,
        AM_CIRC = 3'd3,
        AM_REVC = 3'd4
    } agu_mode_e;
endpackage

// File: rtl/dsp_agu_circ.sv
// Module: circular post-increment for a buffer aligned to a power of two.
// Assumes: length 0 or 1 keeps the pointer still; base = pointer with low
// ceil(log2(length)) bits cleared; offset at or past length-1 wraps to base.
module dsp_agu_circ #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] blk,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] lim;
    logic [AW-1:0] span;
    logic [AW-1:0] off;
    logic [AW-1:0] base;
    logic          at_end;

    // Purpose: last valid offset, zero for an empty buffer.
    assign lim = (blk == '0) ? '0 : blk - AW'(1);

    // Purpose: smear the top set bit of lim downward to form the offset mask.
    for (genvar i = 0; i < AW; i++) begin : g_span
        assign span[i] = |lim[AW-1:i];
    end

    assign off  = ptr & span;
    assign base = ptr & ~span;

    // Purpose: decide whether the next step leaves the buffer.
    assign at_end = ({1'b0, off} + (AW+1)'(1)) >= {1'b0, blk};
    assign nxt    = at_end ? base : ptr + AW'(1);

    // Purpose: the wrapped or stepped pointer stays in the same aligned block (R6).
    always_comb begin
        a_r6_same_block: assert ((nxt & ~span) == base);
    end
endmodule

// File: rtl/dsp_agu_revadd.sv
// Module: adder whose carry travels from the MSB toward the LSB.
// Assumes: the carry leaving bit 0 is discarded.
module dsp_agu_revadd #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] a_rev;
    logic [AW-1:0] b_rev;
    logic [AW-1:0] s_rev;

    // Purpose: mirror operands and result so a normal adder runs backwards.
    for (genvar i = 0; i < AW; i++) begin : g_mirror
        assign a_rev[i] = a[AW-1-i];
        assign b_rev[i] = b[AW-1-i];
        assign sum[i]   = s_rev[AW-1-i];
    end

    assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/dsp_agu_step.sv
// Module: computes the post-modify value of a pointer for a given mode.
// Assumes: purely combinational; unused codes hold the pointer.
module dsp_agu_step #(
    parameter int AW = 16
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] blk,
    output logic [AW-1:0] nxt
);
    import dsp_agu_pkg::*;

    logic [AW-1:0] circ_nxt;
    logic [AW-1:0] rev_nxt;

    dsp_agu_circ #(.AW(AW)) u_circ (
        .ptr (cur),
        .blk (blk),
        .nxt (circ_nxt)
    );

    dsp_agu_revadd #(.AW(AW)) u_revadd (
        .a   (cur),
        .b   (idx),
        .sum (rev_nxt)
    );

    // Purpose: select the update by mode code.
    always_comb begin
        case (agu_mode_e'(mode))
            AM_INC:  nxt = cur + AW'(1);
            AM_DEC:  nxt = cur - AW'(1);
            AM_CIRC: nxt = circ_nxt;
            AM_REVC: nxt = rev_nxt;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dsp_agu_regfile.sv
// Module: pointer register file with one load port and one update port.
// Assumes: a load beats an update aimed at the same register.
module dsp_agu_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_en,
    input  logic [SELW-1:0]            upd_sel,
    input  logic [AW-1:0]              upd_val,
    input  logic                       ld_en,
    input  logic [SELW-1:0]            ld_sel,
    input  logic [AW-1:0]              ld_val,
    output logic [NREG-1:0][AW-1:0]    ar_q
);
    // Purpose: write each pointer from the load or the update port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ld_en && ld_sel == SELW'(i))
                    ar_q[i] <= ld_val;
                else if (upd_en && upd_sel == SELW'(i))
                    ar_q[i] <= upd_val;
            end
        end
    end

    // Purpose: a load always lands, whatever the update port does (R8).
    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ar_q[$past(ld_sel)] == $past(ld_val));
endmodule

// File: rtl/dsp_agu.sv
// Module: address generation unit top. Holds step and length registers,
// registers the operand address and drives the pointer file.
// Assumes: address appears one cycle after the request, pre-modify value.
module dsp_agu #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [SELW-1:0] req_sel,
    input  logic [2:0]      req_mode,
    input  logic            ld_ar_en,
    input  logic [SELW-1:0] ld_ar_sel,
    input  logic [AW-1:0]   ld_ar_data,
    input  logic            ld_idx_en,
    input  logic [AW-1:0]   ld_idx_data,
    input  logic            ld_blk_en,
    input  logic [AW-1:0]   ld_blk_data,
    output logic [AW-1:0]   addr_out,
    output logic            addr_valid
);
    import dsp_agu_pkg::*;

    logic [NREG-1:0][AW-1:0] ar_q;
    logic [AW-1:0]           idx_q;
    logic [AW-1:0]           blk_q;
    logic [AW-1:0]           cur;
    logic [AW-1:0]           nxt;
    logic                    clash;

    assign cur   = ar_q[req_sel];
    assign clash = ld_ar_en && (ld_ar_sel == req_sel);

    // Purpose: step and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            blk_q <= '0;
        end else begin
            if (ld_idx_en) idx_q <= ld_idx_data;
            if (ld_blk_en) blk_q <= ld_blk_data;
        end
    end

    // Purpose: register the pre-modify address and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) addr_out <= cur;
        end
    end

    dsp_agu_step #(.AW(AW)) u_step (
        .mode (req_mode),
        .cur  (cur),
        .idx  (idx_q),
        .blk  (blk_q),
        .nxt  (nxt)
    );

    dsp_agu_regfile #(.AW(AW), .NREG(NREG)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (req_valid),
        .upd_sel (req_sel),
        .upd_val (nxt),
        .ld_en   (ld_ar_en),
        .ld_sel  (ld_ar_sel),
        .ld_val  (ld_ar_data),
        .ar_q    (ar_q)
    );

    // Purpose: address output timing and content (R2).
    a_r2_addr_pre: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid && addr_out == $past(cur));
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // Purpose: increment and decrement steps land in the file (R4, R5).
    a_r4_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'(AM_INC) && !clash)
        |=> ar_q[$past(req_sel)] == $past(cur) + AW'(1));
    a_r5_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'(AM_DEC) && !clash)
        |=> ar_q[$past(req_sel)] == $past(cur) - AW'(1));

    // Purpose: hold codes keep the pointer (R3).
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'(AM_HOLD) || req_mode > 3'(AM_REVC)) && !clash)
        |=> ar_q[$past(req_sel)] == $past(cur));

    // Purpose: step register load takes effect at the next edge (R9).
    a_r9_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_idx_en |=> idx_q == $past(ld_idx_data));
endmodule

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [2:0]  req_mode = '0;
    logic        ld_ar_en = 1'b0;
    logic [2:0]  ld_ar_sel = '0;
    logic [15:0] ld_ar_data = '0;
    logic        ld_idx_en = 1'b0;
    logic [15:0] ld_idx_data = '0;
    logic        ld_blk_en = 1'b0;
    logic [15:0] ld_blk_data = '0;
    logic [15:0] addr_out;
    logic        addr_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_agu u_dsp_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .ld_ar_en(ld_ar_en), .ld_ar_sel(ld_ar_sel),
        .ld_ar_data(ld_ar_data), .ld_idx_en(ld_idx_en), .ld_idx_data(ld_idx_data),
        .ld_blk_en(ld_blk_en), .ld_blk_data(ld_blk_data),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    // ---------------- behavioural reference model ----------------
    int    m_ar [8];
    int    m_idx, m_blk;
    int    e_addr;
    bit    e_valid;
    bit    model_live = 0;
    string e_tag = "R1";

    function automatic int rev_add(int a, int b);
        int r = 0;
        int c = 0;
        for (int i = 15; i >= 0; i--) begin
            int s = ((a >> i) & 1) + ((b >> i) & 1) + c;
            r = r | ((s & 1) << i);
            c = s >> 1;
        end
        return r;
    endfunction

    function automatic int circ_next(int p, int len);
        int k = 0;
        int base, off;
        if (len <= 1) return p;
        while ((1 << k) < len) k++;
        off  = p % (1 << k);
        base = p - off;
        if (off + 1 >= len) return base;
        return p + 1;
    endfunction

    function automatic int rev_bits(int v, int nb);
        int r = 0;
        for (int i = 0; i < nb; i++) if ((v >> i) & 1) r = r | (1 << (nb - 1 - i));
        return r;
    endfunction

    // Model update at each edge, from inputs driven at the previous falling edge.
    always @(posedge clk) begin
        int nv;
        model_live = 1;
        if (!rst_n) begin
            foreach (m_ar[i]) m_ar[i] = 0;
            m_idx = 0; m_blk = 0; e_valid = 0; e_addr = 0; e_tag = "R1";
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                e_addr = m_ar[req_sel];
                case (req_mode)
                    3'd1: begin nv = (e_addr + 1) & 16'hFFFF;         e_tag = "R4"; end
                    3'd2: begin nv = (e_addr + 65535) & 16'hFFFF;     e_tag = "R5"; end
                    3'd3: begin nv = circ_next(e_addr, m_blk);        e_tag = "R6"; end
                    3'd4: begin nv = rev_add(e_addr, m_idx);          e_tag = "R7"; end
                    default: begin nv = e_addr;                       e_tag = "R3"; end
                endcase
                if (!(ld_ar_en && ld_ar_sel == req_sel)) m_ar[req_sel] = nv;
                else e_tag = "R8";
            end else begin
                e_tag = "R2";
            end
            if (ld_ar_en)  m_ar[ld_ar_sel] = ld_ar_data;
            if (ld_idx_en) begin m_idx = ld_idx_data; e_tag = {e_tag, "/R9"}; end
            if (ld_blk_en) begin m_blk = ld_blk_data; e_tag = {e_tag, "/R9"}; end
        end
    end

    // Compare every cycle at the falling edge (R10 covered via later reads).
    always @(negedge clk) begin
        if (model_live) begin
            checks++;
            if (addr_valid !== e_valid || (e_valid && addr_out !== 16'(e_addr))) begin
                errors++;
                $display("FAIL %s model: valid=%0b addr=%h expected valid=%0b addr=%h",
                         e_tag, addr_valid, addr_out, e_valid, 16'(e_addr));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle_inputs();
        req_valid = 0; ld_ar_en = 0; ld_idx_en = 0; ld_blk_en = 0;
    endtask

    task automatic load_ar(int sel, int val);
        ld_ar_en = 1; ld_ar_sel = 3'(sel); ld_ar_data = 16'(val);
        @(negedge clk); idle_inputs();
    endtask

    task automatic load_cfg(int idx, int len);
        ld_idx_en = 1; ld_idx_data = 16'(idx);
        ld_blk_en = 1; ld_blk_data = 16'(len);
        @(negedge clk); idle_inputs();
    endtask

    task automatic access(int sel, int mode, int exp, string tag);
        req_valid = 1; req_sel = 3'(sel); req_mode = 3'(mode);
        @(negedge clk);
        idle_inputs();
        checks++;
        if (!addr_valid || addr_out !== 16'(exp)) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%0b expected addr=%h", tag, addr_out, addr_valid, 16'(exp));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (addr_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: addr_valid=%0b expected 0", addr_valid);
        end
        rst_n = 1;
        @(negedge clk);

        // R1: every pointer reads zero after reset (mode 0 is hold, R3)
        for (int i = 0; i < 8; i++) access(i, 0, 0, "R1");
        access(3, 0, 0, "R3 hold");

        // R4 / R5: wrap of increment and decrement
        load_ar(1, 16'hFFFF);
        access(1, 1, 16'hFFFF, "R4");
        access(1, 2, 16'h0000, "R4 wrap");
        access(1, 6, 16'hFFFF, "R5 wrap");
        access(1, 0, 16'hFFFF, "R3 code6");

        // R7: bit-reversed walk for N=8 and N=16
        load_cfg(4, 0);
        load_ar(0, 0);
        for (int i = 0; i < 8; i++) access(0, 4, rev_bits(i, 3), "R7 N=8");
        access(0, 0, 0, "R7 N=8 return");
        load_cfg(8, 0);
        for (int i = 0; i < 16; i++) access(0, 4, rev_bits(i, 4), "R7 N=16");

        // R6: length 5 (not a power of two), base 0x20
        load_cfg(0, 5);
        load_ar(2, 16'h0020);
        for (int i = 0; i < 12; i++) access(2, 3, 16'h0020 + (i % 5), "R6 len5");
        load_ar(2, 16'h0027);
        access(2, 3, 16'h0027, "R6 out of range");
        access(2, 0, 16'h0020, "R6 wrap to base");
        load_cfg(0, 1);
        access(2, 3, 16'h0020, "R6 len1");
        access(2, 0, 16'h0020, "R6 len1 hold");

        // R10: other pointers untouched by all that traffic
        access(5, 0, 0, "R10");

        // R8: load and increment of the same pointer in one cycle
        load_ar(4, 16'h0050);
        ld_ar_en = 1; ld_ar_sel = 3'd4; ld_ar_data = 16'h0100;
        access(4, 1, 16'h0050, "R8 same-cycle addr");
        access(4, 0, 16'h0100, "R8 load wins");
        // R8: load of another pointer while incrementing this one
        ld_ar_en = 1; ld_ar_sel = 3'd6; ld_ar_data = 16'h0777;
        access(4, 1, 16'h0100, "R8 other");
        access(4, 0, 16'h0101, "R8 other updated");
        access(6, 0, 16'h0777, "R8 other loaded");

        // R9: step load in the same cycle uses the old step
        load_cfg(8, 0);
        load_ar(7, 0);
        ld_idx_en = 1; ld_idx_data = 16'h4000;
        access(7, 4, 0, "R9 same-cycle");
        access(7, 4, 16'h0008, "R9 old step used");
        access(7, 0, 16'h4008, "R9 new step used");

        // Random traffic judged by the reference model
        for (int n = 0; n < 2000; n++) begin
            req_valid = ($urandom % 4) != 0;
            req_sel   = 3'($urandom);
            req_mode  = 3'($urandom);
            ld_ar_en  = ($urandom % 6) == 0;
            ld_ar_sel = 3'($urandom);
            ld_ar_data = 16'($urandom);
            ld_idx_en = ($urandom % 20) == 0;
            ld_idx_data = 16'(1 << ($urandom % 16));
            ld_blk_en = ($urandom % 20) == 0;
            ld_blk_data = 16'($urandom % 40);
            @(negedge clk);
        end
        idle_inputs();
        @(negedge clk);
        finish_run();
    end
endmodule